// File: doc/BRIEF.md
# Colour-Subcarrier Phase Reset and Serial Frequency Receiver

This block sits in front of a colour-subcarrier phase accumulator. It serves one shared control pin, and a 2-bit role field decides how that pin is read. In phase-reset role, a rising edge on the pin does not act at once. The block stores it as a request and releases it as a one-cycle `phase_reset` pulse when the next field starts. The accumulator then returns to its field-0 phase.

In serial-frequency role, a companion video decoder streams a 67-bit frame on the pin at two clocks per bit. A low-to-high start marker opens each frame. The block samples every bit, collects the frame in a shift register and takes the 22-bit frequency field from frame bits 0 to 21. It then presents that value as a new frequency word with a one-cycle strobe. Frames arrive once per line, so the accumulator follows line-length variation line by line. While this role is active, the programmable frequency registers elsewhere should be set to zero, and the received word stands in for them. The accumulator and the sine lookup lie outside this block.

Top module: `subcarrier_ctrl_rx`

## Requirements
- R1: While `rst_n` is low and after its release, `freq_word` is 0 and `freq_update` and `phase_reset` are 0 until pin activity in an active role.
- R2: `pin_mode` encoding: 2'b00 and 2'b11 ignore the pin; 2'b01 is phase-reset role; 2'b10 is serial-frequency role. In the ignore codes neither output pulses. In 2'b01 no frequency update occurs, and in 2'b10 no phase reset occurs.
- R3: In role 2'b01, a rising edge on `ctrl_pin` arms a request. The next cycle in which `field_start` is sampled high then gives `phase_reset` high for exactly the following cycle.
- R4: A `field_start` with no armed request gives no pulse. After a pulse the request is gone, so a later `field_start` gives nothing until a new edge.
- R5: Any number of edges while a request is armed merge into one pulse.
- R6: An edge detected in the same cycle as `field_start` is served at the next `field_start`, not at the current one.
- R7: Leaving role 2'b01 discards an armed request.
- R8: In role 2'b10, a frame is the pin held low, then high for one bit period (the start marker), then 67 bits, frame bit 0 first. Each bit is two clock periods long.
- R9: After a frame, `freq_word` equals frame bits 21..0, with frame bit 0 as its LSB; bits 22..66 are discarded. Take the rising edge that first samples the marker as edge 0. `freq_word` changes and `freq_update` is high only in the cycle after edge 137.
- R10: `freq_word` keeps its value between updates, and `freq_update` lasts one cycle.
- R11: Leaving role 2'b10 in the middle of a frame abandons it: no update, and `freq_word` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_mode | input | 2 | Role of the shared control pin |
| ctrl_pin | input | 1 | Shared control pin, asynchronous |
| field_start | input | 1 | One-cycle pulse at the start of each field |
| phase_reset | output | 1 | One-cycle request to reset the subcarrier to field-0 phase |
| freq_word | output | 22 | Latest received subcarrier frequency word |
| freq_update | output | 1 | One-cycle strobe when `freq_word` takes a new value |

## Verification
Two cases are hard to reach from the ports.

The first is an edge that lands in exactly the cycle that samples `field_start`. The two-flop synchroniser delays every pin change by two edges, so the bench raises the pin and then drives `field_start` two clocks later. The deferred request is then checked to stay silent at that field and to fire at the next one.

The second is a frame that has to be abandoned. The bench changes the role in the middle of a frame and then sends a full frame. This proves that the receiver returned to idle and did not treat leftover data bits as a start marker.

// File: rtl/scr_rx_pkg.sv
package scr_rx_pkg;

    typedef enum logic [1:0] {
        PIN_OFF         = 2'b00,
        PIN_PHASE_RST   = 2'b01,
        PIN_FREQ_STREAM = 2'b10,
        PIN_OFF_ALT     = 2'b11
    } pin_role_e;

    typedef enum logic [1:0] {
        RX_IDLE = 2'b00,
        RX_MARK = 2'b01,
        RX_DATA = 2'b10
    } rx_state_e;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o
);
    // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
    typedef struct packed {
        logic [STAGES:0] chain;
    } sync_regs_t;

    sync_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.chain = {cur_q.chain[STAGES-1:0], pin_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign level_o = cur_q.chain[STAGES-1];
    assign rise_o  = cur_q.chain[STAGES-1] & ~cur_q.chain[STAGES];
endmodule

// File: rtl/phase_reset_ctrl.sv
module phase_reset_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic rise_i,
    input  logic field_start_i,
    output logic phase_reset_o
);
    typedef struct packed {
        logic pending;
        logic fire;
    } prc_regs_t;

    prc_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (!enable_i) begin
            nxt_d.pending = 1'b0;
            nxt_d.fire    = 1'b0;
        end else begin
            // a pending request is served at this field start; a new edge waits for the next one
            nxt_d.fire    = cur_q.pending & field_start_i;
            nxt_d.pending = rise_i | (cur_q.pending & ~field_start_i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign phase_reset_o = cur_q.fire;
endmodule

// File: rtl/freq_frame_rx.sv
module freq_frame_rx
    import scr_rx_pkg::*;
#(
    parameter int FRAME_BITS   = 67,
    parameter int CLKS_PER_BIT = 2,
    parameter int FIELD_LSB    = 0,
    parameter int FIELD_W      = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable_i,
    input  logic               level_i,
    input  logic               rise_i,
    output logic [FIELD_W-1:0] word_o,
    output logic               update_o
);
    localparam int IDX_W  = $clog2(FRAME_BITS);
    localparam int TICK_W = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(CLKS_PER_BIT - 1);
    localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(FRAME_BITS - 1);

    typedef struct packed {
        rx_state_e              state;
        logic [TICK_W-1:0]      tick;
        logic [IDX_W-1:0]       idx;
        logic [FRAME_BITS-1:0]  shreg;
        logic [FIELD_W-1:0]     word;
        logic                   upd;
    } rx_regs_t;

    rx_regs_t cur_q, nxt_d;
    logic [FRAME_BITS-1:0] shifted;

    always_comb begin
        nxt_d   = cur_q;
        nxt_d.upd = 1'b0;
        shifted = {level_i, cur_q.shreg[FRAME_BITS-1:1]};
        if (!enable_i) begin
            nxt_d.state = RX_IDLE;
            nxt_d.tick  = '0;
            nxt_d.idx   = '0;
        end else begin
            unique case (cur_q.state)
                RX_IDLE: begin
                    if (rise_i) begin
                        // the marker's first cycle is this one
                        nxt_d.state = RX_MARK;
                        nxt_d.tick  = TICK_W'(1);
                        nxt_d.idx   = '0;
                    end
                end
                RX_MARK: begin
                    if (cur_q.tick == LAST_TICK) begin
                        nxt_d.tick  = '0;
                        nxt_d.state = RX_DATA;
                    end else begin
                        nxt_d.tick = cur_q.tick + TICK_W'(1);
                    end
                end
                RX_DATA: begin
                    if (cur_q.tick == LAST_TICK) begin
                        nxt_d.tick  = '0;
                        nxt_d.shreg = shifted;
                        if (cur_q.idx == LAST_IDX) begin
                            nxt_d.word  = shifted[FIELD_LSB +: FIELD_W];
                            nxt_d.upd   = 1'b1;
                            nxt_d.state = RX_IDLE;
                            nxt_d.idx   = '0;
                        end else begin
                            nxt_d.idx = cur_q.idx + IDX_W'(1);
                        end
                    end else begin
                        nxt_d.tick = cur_q.tick + TICK_W'(1);
                    end
                end
                default: nxt_d.state = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.state <= RX_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign word_o   = cur_q.word;
    assign update_o = cur_q.upd;
endmodule

// File: rtl/subcarrier_ctrl_rx.sv
module subcarrier_ctrl_rx
    import scr_rx_pkg::*;
#(
    parameter int FRAME_BITS   = 67,
    parameter int CLKS_PER_BIT = 2,
    parameter int FIELD_LSB    = 0,
    parameter int FIELD_W      = 22,
    parameter int SYNC_STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         pin_mode,
    input  logic               ctrl_pin,
    input  logic               field_start,
    output logic               phase_reset,
    output logic [FIELD_W-1:0] freq_word,
    output logic               freq_update
);
    pin_role_e role;
    logic      pin_level;
    logic      pin_rise;
    logic      rst_role;
    logic      stream_role;

    assign role        = pin_role_e'(pin_mode);
    assign rst_role    = (role == PIN_PHASE_RST);
    assign stream_role = (role == PIN_FREQ_STREAM);

    pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (ctrl_pin),
        .level_o (pin_level),
        .rise_o  (pin_rise)
    );

    phase_reset_ctrl u_phase (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable_i      (rst_role),
        .rise_i        (pin_rise),
        .field_start_i (field_start),
        .phase_reset_o (phase_reset)
    );

    freq_frame_rx #(
        .FRAME_BITS   (FRAME_BITS),
        .CLKS_PER_BIT (CLKS_PER_BIT),
        .FIELD_LSB    (FIELD_LSB),
        .FIELD_W      (FIELD_W)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (stream_role),
        .level_i  (pin_level),
        .rise_i   (pin_rise),
        .word_o   (freq_word),
        .update_o (freq_update)
    );
endmodule

// File: rtl/subcarrier_ctrl_rx_chk.sv
module subcarrier_ctrl_rx_chk #(
    parameter int FIELD_W = 22
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         pin_mode,
    input logic               field_start,
    input logic               phase_reset,
    input logic [FIELD_W-1:0] freq_word,
    input logic               freq_update
);
    a_r3_reset_after_field: assert property (@(posedge clk) disable iff (!rst_n)
        phase_reset |-> ($past(field_start) && $past(pin_mode) == 2'b01));

    a_r3_reset_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        phase_reset |=> !phase_reset);

    a_r2_update_needs_stream: assert property (@(posedge clk) disable iff (!rst_n)
        freq_update |-> ($past(pin_mode) == 2'b10));

    a_r10_update_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        freq_update |=> !freq_update);

    a_r10_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        !freq_update |-> $stable(freq_word));
endmodule

bind subcarrier_ctrl_rx subcarrier_ctrl_rx_chk #(.FIELD_W(FIELD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_mode    (pin_mode),
    .field_start (field_start),
    .phase_reset (phase_reset),
    .freq_word   (freq_word),
    .freq_update (freq_update)
);

// File: tb/subcarrier_ctrl_rx_bench.sv
module subcarrier_ctrl_rx_bench;
    localparam int NVEC = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  pin_mode = 2'b00;
    logic        ctrl_pin = 1'b0;
    logic        field_start = 1'b0;
    logic        phase_reset;
    logic [21:0] freq_word;
    logic        freq_update;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // frame = {filler bits 66..22, frequency field bits 21..0}
    localparam logic [66:0] FRAMES [NVEC] = '{
        {45'h1FFF_FFFF_FFFF, 22'h3FFFFF},
        {45'h1FFF_FFFF_FFFF, 22'h000000},
        {45'h0000_0000_0000, 22'h2AAAAA},
        {45'h0AAA_5555_AAAA, 22'h155555},
        {45'h1234_5678_9ABC, 22'h0F0F0F}
    };
    localparam logic [21:0] EXPECT [NVEC] = '{
        22'h3FFFFF, 22'h000000, 22'h2AAAAA, 22'h155555, 22'h0F0F0F
    };

    subcarrier_ctrl_rx u_subcarrier_ctrl_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_mode    (pin_mode),
        .ctrl_pin    (ctrl_pin),
        .field_start (field_start),
        .phase_reset (phase_reset),
        .freq_word   (freq_word),
        .freq_update (freq_update)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // marker bit and 67 data bits, each held for two clocks; pin left low after
    task automatic send_frame(input logic [66:0] fr);
        ctrl_pin = 1'b0;
        idle(4);
        @(negedge clk) ctrl_pin = 1'b1;
        @(negedge clk) ctrl_pin = 1'b1;
        for (int b = 0; b < 67; b++) begin
            @(negedge clk) ctrl_pin = fr[b];
            @(negedge clk) ctrl_pin = fr[b];
        end
    endtask

    // after send_frame: strobe expected on the third negedge only
    task automatic expect_update(input bit want, input logic [21:0] word, input string tag);
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (k == 1) ctrl_pin = 1'b0;
            if (k == 3 && want) begin
                check(freq_update == 1'b1, tag, 32'(freq_update), 32'd1);
                check(freq_word == word, tag, 32'(freq_word), 32'(word));
            end else begin
                check(freq_update == 1'b0, tag, 32'(freq_update), 32'd0);
            end
        end
        if (!want) check(freq_word == word, tag, 32'(freq_word), 32'(word));
    endtask

    task automatic pulse_field(input bit want, input string tag);
        @(negedge clk) field_start = 1'b1;
        @(negedge clk) field_start = 1'b0;
        check(phase_reset == want, tag, 32'(phase_reset), 32'(want));
        @(negedge clk);
        check(phase_reset == 1'b0, tag, 32'(phase_reset), 32'd0);
    endtask

    task automatic raise_pin();
        @(negedge clk) ctrl_pin = 1'b0;
        idle(3);
        @(negedge clk) ctrl_pin = 1'b1;
        idle(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [21:0] held;
        // R1 reset state
        idle(4);
        check(freq_word == 22'd0 && freq_update == 1'b0 && phase_reset == 1'b0,
              "R1 reset outputs", 32'(freq_word), 32'd0);
        @(negedge clk) rst_n = 1'b1;
        idle(2);
        check(freq_word == 22'd0 && !freq_update && !phase_reset,
              "R1 after release", 32'(freq_word), 32'd0);

        // R8 R9 vector table walk in serial-frequency role
        pin_mode = 2'b10;
        for (int v = 0; v < NVEC; v++) begin
            send_frame(FRAMES[v]);
            expect_update(1'b1, EXPECT[v], "R9 frame field");
        end
        held = freq_word;

        // R2 ignore codes and the wrong role
        pin_mode = 2'b00;
        send_frame(FRAMES[3]);
        expect_update(1'b0, held, "R2 mode 00 no update");
        pin_mode = 2'b11;
        send_frame(FRAMES[3]);
        expect_update(1'b0, held, "R2 mode 11 no update");
        pin_mode = 2'b01;
        send_frame(FRAMES[3]);
        expect_update(1'b0, held, "R2 reset role no update");
        pulse_field(1'b1, "R3 frame edges arm reset");
        pin_mode = 2'b00;
        raise_pin();
        pulse_field(1'b0, "R2 mode 00 no reset");
        pin_mode = 2'b11;
        raise_pin();
        pulse_field(1'b0, "R2 mode 11 no reset");
        pin_mode = 2'b10;
        idle(2);
        raise_pin();
        pulse_field(1'b0, "R2 stream role no reset");
        ctrl_pin = 1'b0;
        idle(300);

        // R3 R4 deferred reset
        pin_mode = 2'b01;
        idle(4);
        pulse_field(1'b0, "R4 nothing pending");
        raise_pin();
        check(phase_reset == 1'b0, "R3 not immediate", 32'(phase_reset), 32'd0);
        pulse_field(1'b1, "R3 reset at field start");
        pulse_field(1'b0, "R4 request cleared");

        // R5 merge
        raise_pin();
        raise_pin();
        raise_pin();
        pulse_field(1'b1, "R5 merged pulse");
        pulse_field(1'b0, "R5 single pulse only");

        // R6 edge in the field-start cycle
        @(negedge clk) ctrl_pin = 1'b0;
        idle(4);
        @(negedge clk) ctrl_pin = 1'b1;
        @(negedge clk);
        @(negedge clk) field_start = 1'b1;
        @(negedge clk) field_start = 1'b0;
        check(phase_reset == 1'b0, "R6 coincident edge deferred", 32'(phase_reset), 32'd0);
        idle(3);
        pulse_field(1'b1, "R6 served next field");

        // R7 leaving the role drops the request
        raise_pin();
        @(negedge clk) pin_mode = 2'b00;
        @(negedge clk) pin_mode = 2'b01;
        idle(2);
        pulse_field(1'b0, "R7 request discarded");

        // R11 abandoned frame, then a full one
        ctrl_pin = 1'b0;
        pin_mode = 2'b10;
        held = freq_word;
        idle(4);
        @(negedge clk) ctrl_pin = 1'b1;
        @(negedge clk) ctrl_pin = 1'b1;
        for (int b = 0; b < 30; b++) begin
            @(negedge clk) ctrl_pin = b[0];
            @(negedge clk) ctrl_pin = b[0];
        end
        @(negedge clk) pin_mode = 2'b00;
        for (int i = 0; i < 150; i++) begin
            @(negedge clk) ctrl_pin = i[1];
            if (freq_update) check(1'b0, "R11 abandoned frame updated", 32'd1, 32'd0);
        end
        check(freq_word == held, "R11 word unchanged", 32'(freq_word), 32'(held));
        pin_mode = 2'b10;
        send_frame(FRAMES[4]);
        expect_update(1'b1, EXPECT[4], "R11 recovery frame");
        idle(20);
        check(freq_word == EXPECT[4] && !freq_update, "R10 word held",
              32'(freq_word), 32'(EXPECT[4]));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule